// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the 32-bit datapath of a processor that runs each instruction over several clock cycles. A single internal word memory is shared in time between instruction fetch and data access. Values are carried from one cycle to the next in staging registers: an instruction register, a memory data register, two operand registers, and an ALU result register. Each of these, and the program counter, has its own load enable. The block also holds a 32-entry register file, an ALU, and select muxes for the memory address, the register-file write port, both ALU operands and the next PC.

All control comes from an external sequencer, which is not part of this block. The sequencer drives the enables and selects each cycle. It reads back the instruction fields and the ALU zero flag to choose its next state. The PC has two load enables: one unconditional, and one conditional that takes effect only when the ALU result is zero. The condition is resolved inside the block. A preload write port puts words into memory before execution starts.

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the PC, instruction, data, operand and result registers all clear to zero.
- R2: Each staging register loads on a clock edge only when its own enable is high, and otherwise keeps its value. The instruction register stays unchanged even if the memory word it came from is rewritten.
- R3: The memory word index is taken from bits [11:2] of the address. With `iord`=0 the address is the PC, and with `iord`=1 it is the result register. When `mem_we` is high, operand register B is written to the addressed word at the clock edge. Reads are combinational.
- R4: Operand A loads from register IR[25:21] and operand B loads from register IR[20:16]. Register 0 always reads as zero, and a write to it has no effect.
- R5: When `rf_we` is high, `rdst_sel`=1 writes register IR[15:11] and `rdst_sel`=0 writes register IR[20:16]. `m2r_sel`=0 writes the result register, and `m2r_sel`=1 writes the memory data register.
- R6: `asrc1_sel`=0 feeds the PC into the first ALU input, and 1 feeds A. `asrc2_sel` feeds the second ALU input: 0 gives B, 1 gives the constant 4, 2 gives sign-extended IR[15:0], and 3 gives sign-extended IR[15:0] shifted left by two.
- R7: `alu_fn` codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0), 5 XOR. `alu_zero` is high exactly when the ALU output is zero.
- R8: The next-PC source: `pc_src`=0 selects the result register, 1 selects the ALU output, and 2 selects {PC[31:28], IR[25:0], 2'b00}.
- R9: The PC loads when `pc_wr_u` is high, or when `pc_wr_c` and `alu_zero` are both high. Otherwise it holds.
- R10: When `init_we` is high, `init_data` is written to memory word `init_addr` at the clock edge. This write takes priority over `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr_u | input | 1 | Unconditional PC load |
| pc_wr_c | input | 1 | PC load when ALU result is zero |
| pc_src | input | 2 | Next-PC source select |
| ir_we | input | 1 | Instruction register load |
| dr_we | input | 1 | Memory data register load |
| a_we | input | 1 | Operand A load |
| b_we | input | 1 | Operand B load |
| res_we | input | 1 | Result register load |
| iord | input | 1 | Memory address select (PC / result) |
| mem_we | input | 1 | Memory write from operand B |
| rf_we | input | 1 | Register file write |
| rdst_sel | input | 1 | Write address select (rt / rd) |
| m2r_sel | input | 1 | Write data select (result / memory data) |
| asrc1_sel | input | 1 | First ALU operand select |
| asrc2_sel | input | 2 | Second ALU operand select |
| alu_fn | input | 3 | ALU function code |
| init_we | input | 1 | Preload write strobe |
| init_addr | input | 10 | Preload word index |
| init_data | input | 32 | Preload word |
| pc | output | 32 | Program counter |
| ir_op | output | 6 | IR[31:26] |
| ir_rs | output | 5 | IR[25:21] |
| ir_rt | output | 5 | IR[20:16] |
| ir_rd | output | 5 | IR[15:11] |
| ir_shamt | output | 5 | IR[10:6] |
| ir_funct | output | 6 | IR[5:0] |
| alu_zero | output | 1 | ALU output equals zero |

## Verification
The properties assume the following about the inputs:
- Control inputs change only away from the clock edge.
- `pc_src` never takes the unused code 3 while the PC is being loaded.
- The preload port and `mem_we` never target the same word in the same cycle.

The directed stimulus meets these assumptions in the following way. Controls are driven one time unit after each rising edge, and all enables are cleared after every cycle. Only the three defined PC sources are used. Preload writes are issued only in cycles with no store.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RADDR_W = $clog2(NREGS);

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4,
        ALU_XOR = 3'd5
    } alu_fn_e;

    typedef enum logic [1:0] {
        OPB_REG   = 2'd0,
        OPB_FOUR  = 2'd1,
        OPB_IMM   = 2'd2,
        OPB_BRIMM = 2'd3
    } opb_sel_e;

    typedef enum logic [1:0] {
        NPC_RES  = 2'd0,
        NPC_ALU  = 2'd1,
        NPC_JUMP = 2'd2
    } npc_sel_e;

    typedef struct packed {
        logic [5:0]         op;
        logic [RADDR_W-1:0] rs;
        logic [RADDR_W-1:0] rt;
        logic [RADDR_W-1:0] rd;
        logic [4:0]         shamt;
        logic [5:0]         funct;
    } instr_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pcv,
                                                  input instr_t ins);
        return {pcv[XLEN-1:XLEN-4], ins[25:0], 2'b00};
    endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu import mc_dp_pkg::*; #(
    parameter int W = XLEN
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  alu_fn_e      fn,
    output logic [W-1:0] r,
    output logic         zero
);
    always_comb begin
        case (fn)
            ALU_SUB: r = x - y;
            ALU_AND: r = x & y;
            ALU_OR:  r = x | y;
            ALU_SLT: r = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            ALU_XOR: r = x ^ y;
            default: r = x + y;
        endcase
    end

    assign zero = (r == '0);
endmodule

// File: rtl/mc_memory.sv
module mc_memory #(
    parameter int W     = 32,
    parameter int WORDS = 1024,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic [AW-1:0] idx,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          init_we,
    input  logic [AW-1:0] init_idx,
    input  logic [W-1:0]  init_data
);
    logic [W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (init_we)  words[init_idx] <= init_data;
        else if (we)  words[idx]      <= wdata;
    end

    assign rdata = words[idx];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath import mc_dp_pkg::*; #(
    parameter int MEM_WORDS = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pc_wr_u,
    input  logic                         pc_wr_c,
    input  logic [1:0]                   pc_src,
    input  logic                         ir_we,
    input  logic                         dr_we,
    input  logic                         a_we,
    input  logic                         b_we,
    input  logic                         res_we,
    input  logic                         iord,
    input  logic                         mem_we,
    input  logic                         rf_we,
    input  logic                         rdst_sel,
    input  logic                         m2r_sel,
    input  logic                         asrc1_sel,
    input  logic [1:0]                   asrc2_sel,
    input  logic [2:0]                   alu_fn,
    input  logic                         init_we,
    input  logic [$clog2(MEM_WORDS)-1:0] init_addr,
    input  logic [XLEN-1:0]              init_data,
    output logic [XLEN-1:0]              pc,
    output logic [5:0]                   ir_op,
    output logic [RADDR_W-1:0]           ir_rs,
    output logic [RADDR_W-1:0]           ir_rt,
    output logic [RADDR_W-1:0]           ir_rd,
    output logic [4:0]                   ir_shamt,
    output logic [5:0]                   ir_funct,
    output logic                         alu_zero
);
    localparam int MEM_AW = $clog2(MEM_WORDS);

    instr_t            ir_q;
    logic [XLEN-1:0]   pc_q, dr_q, a_q, b_q, res_q;
    logic [XLEN-1:0]   mem_addr, mem_rdata;
    logic [XLEN-1:0]   rf_rd1, rf_rd2, rf_wd;
    logic [RADDR_W-1:0] rf_wa;
    logic [XLEN-1:0]   opa, opb, alu_y, pc_next;
    logic              pc_load;
    logic [XLEN-MEM_AW-1:0] unused_addr_bits;

    // memory address and shared memory
    assign mem_addr = iord ? res_q : pc_q;
    assign unused_addr_bits = {mem_addr[XLEN-1:MEM_AW+2], mem_addr[1:0]};

    mc_memory #(.W(XLEN), .WORDS(MEM_WORDS), .AW(MEM_AW)) u_mem (
        .clk       (clk),
        .idx       (mem_addr[MEM_AW+1:2]),
        .we        (mem_we),
        .wdata     (b_q),
        .rdata     (mem_rdata),
        .init_we   (init_we),
        .init_idx  (init_addr),
        .init_data (init_data)
    );

    // register file with write-port selects
    assign rf_wa = rdst_sel ? ir_q.rd : ir_q.rt;
    assign rf_wd = m2r_sel  ? dr_q    : res_q;

    mc_regfile #(.W(XLEN), .N(NREGS), .AW(RADDR_W)) u_rf (
        .clk (clk),
        .ra1 (ir_q.rs),
        .ra2 (ir_q.rt),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .we  (rf_we),
        .wa  (rf_wa),
        .wd  (rf_wd)
    );

    // ALU operand selection
    assign opa = asrc1_sel ? a_q : pc_q;

    always_comb begin
        case (opb_sel_e'(asrc2_sel))
            OPB_REG:   opb = b_q;
            OPB_FOUR:  opb = XLEN'(4);
            OPB_IMM:   opb = sext16(ir_q[15:0]);
            default:   opb = sext16(ir_q[15:0]) << 2;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .x    (opa),
        .y    (opb),
        .fn   (alu_fn_e'(alu_fn)),
        .r    (alu_y),
        .zero (alu_zero)
    );

    // next PC
    always_comb begin
        case (npc_sel_e'(pc_src))
            NPC_RES:  pc_next = res_q;
            NPC_JUMP: pc_next = jump_dest(pc_q, ir_q);
            default:  pc_next = alu_y;
        endcase
    end

    assign pc_load = pc_wr_u | (pc_wr_c & alu_zero);

    // staging registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            dr_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
        end else begin
            if (pc_load) pc_q  <= pc_next;
            if (ir_we)   ir_q  <= instr_t'(mem_rdata);
            if (dr_we)   dr_q  <= mem_rdata;
            if (a_we)    a_q   <= rf_rd1;
            if (b_we)    b_q   <= rf_rd2;
            if (res_we)  res_q <= alu_y;
        end
    end

    assign pc       = pc_q;
    assign ir_op    = ir_q.op;
    assign ir_rs    = ir_q.rs;
    assign ir_rt    = ir_q.rt;
    assign ir_rd    = ir_q.rd;
    assign ir_shamt = ir_q.shamt;
    assign ir_funct = ir_q.funct;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic        pc_wr_u,
    input logic        pc_wr_c,
    input logic [1:0]  pc_src,
    input logic        ir_we,
    input logic        a_we,
    input logic        asrc1_sel,
    input logic [1:0]  asrc2_sel,
    input logic [2:0]  alu_fn,
    input logic        alu_zero,
    input logic [31:0] pc,
    input logic [31:0] ir_word,
    input logic [31:0] a_q
);
    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> pc == 32'd0);

    a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
        !ir_we |=> $stable(ir_word));

    a_r4_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (a_we && ir_word[25:21] == 5'd0) |=> a_q == 32'd0);

    a_r8_pc_plus4: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_u && pc_src == 2'd1 && !asrc1_sel && asrc2_sel == 2'd1 && alu_fn == 3'd0)
        |=> pc == $past(pc) + 32'd4);

    a_r8_jump: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_u && pc_src == 2'd2)
        |=> pc == {$past(pc[31:28]), $past(ir_word[25:0]), 2'b00});

    a_r9_pc_idle: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr_u && !pc_wr_c) |=> $stable(pc));

    a_r9_cond_miss: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr_u && pc_wr_c && !alu_zero) |=> $stable(pc));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc_wr_u   (pc_wr_u),
    .pc_wr_c   (pc_wr_c),
    .pc_src    (pc_src),
    .ir_we     (ir_we),
    .a_we      (a_we),
    .asrc1_sel (asrc1_sel),
    .asrc2_sel (asrc2_sel),
    .alu_fn    (alu_fn),
    .alu_zero  (alu_zero),
    .pc        (pc),
    .ir_word   ({ir_op, ir_rs, ir_rt, ir_rd, ir_shamt, ir_funct}),
    .a_q       (a_q)
);

// File: tb/mc_datapath_bench.sv
`timescale 1ns/1ps
module mc_datapath_bench;
    logic clk = 1'b0;
    logic rst;
    logic pc_wr_u, pc_wr_c, ir_we, dr_we, a_we, b_we, res_we, iord, mem_we;
    logic rf_we, rdst_sel, m2r_sel, asrc1_sel, init_we;
    logic [1:0] pc_src, asrc2_sel;
    logic [2:0] alu_fn;
    logic [9:0] init_addr;
    logic [31:0] init_data;
    logic [31:0] pc;
    logic [5:0] ir_op, ir_funct;
    logic [4:0] ir_rs, ir_rt, ir_rd, ir_shamt;
    logic alu_zero;
    logic [31:0] ir_word;
    int n_chk = 0;
    int n_fail = 0;

    assign ir_word = {ir_op, ir_rs, ir_rt, ir_rd, ir_shamt, ir_funct};

    always #4 clk = ~clk;

    mc_datapath u_mc_datapath (
        .clk(clk), .rst(rst), .pc_wr_u(pc_wr_u), .pc_wr_c(pc_wr_c), .pc_src(pc_src),
        .ir_we(ir_we), .dr_we(dr_we), .a_we(a_we), .b_we(b_we), .res_we(res_we),
        .iord(iord), .mem_we(mem_we), .rf_we(rf_we), .rdst_sel(rdst_sel),
        .m2r_sel(m2r_sel), .asrc1_sel(asrc1_sel), .asrc2_sel(asrc2_sel),
        .alu_fn(alu_fn), .init_we(init_we), .init_addr(init_addr),
        .init_data(init_data), .pc(pc), .ir_op(ir_op), .ir_rs(ir_rs),
        .ir_rt(ir_rt), .ir_rd(ir_rd), .ir_shamt(ir_shamt), .ir_funct(ir_funct),
        .alu_zero(alu_zero)
    );

    task automatic clear_ctl();
        {pc_wr_u, pc_wr_c, ir_we, dr_we, a_we, b_we, res_we, iord, mem_we} = '0;
        {rf_we, rdst_sel, m2r_sel, asrc1_sel, init_we} = '0;
        pc_src = 2'd0; asrc2_sel = 2'd0; alu_fn = 3'd0;
        init_addr = '0; init_data = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        clear_ctl();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R10 preload
    task automatic poke_mem(input int idx, input logic [31:0] d);
        init_we = 1'b1; init_addr = 10'(idx); init_data = d;
        cyc();
    endtask

    // load IR from the word at PC (R3 iord=0, R10)
    task automatic load_ir(input logic [31:0] w);
        poke_mem(int'(pc[11:2]), w);
        iord = 1'b0; ir_we = 1'b1;
        cyc();
        chk("R10 preload then fetch via PC (R3)", ir_word, w);
    endtask

    task automatic lw_reg(input logic [4:0] rt, input logic [4:0] base, input logic [15:0] off);
        load_ir({6'h23, base, rt, off});
        a_we = 1'b1; cyc();
        asrc1_sel = 1'b1; asrc2_sel = 2'd2; alu_fn = 3'd0; res_we = 1'b1; cyc();
        iord = 1'b1; dr_we = 1'b1; cyc();
        rf_we = 1'b1; rdst_sel = 1'b0; m2r_sel = 1'b1; cyc();
    endtask

    task automatic peek_reg(input logic [4:0] r, output logic [31:0] val);
        load_ir({6'h2b, 5'd0, r, 16'd3600});
        b_we = 1'b1; a_we = 1'b1; cyc();
        asrc1_sel = 1'b1; asrc2_sel = 2'd2; alu_fn = 3'd0; res_we = 1'b1; cyc();
        iord = 1'b1; mem_we = 1'b1; cyc();
        iord = 1'b1; ir_we = 1'b1; cyc();
        val = ir_word;
    endtask

    task automatic rtype(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt,
                         input logic [2:0] fn);
        load_ir({6'h00, rs, rt, rd, 5'd0, 6'h20});
        a_we = 1'b1; b_we = 1'b1; cyc();
        asrc1_sel = 1'b1; asrc2_sel = 2'd0; alu_fn = fn; res_we = 1'b1; cyc();
        rf_we = 1'b1; rdst_sel = 1'b1; m2r_sel = 1'b0; cyc();
    endtask

    localparam logic [31:0] V5 = 32'h1234_5678;
    localparam logic [31:0] V6 = 32'hFFFF_0003;

    task automatic t_reset();
        chk("R1 pc after reset", pc, 32'd0);
        chk("R1 IR after reset", ir_word, 32'd0);
    endtask

    task automatic t_load_store();
        logic [31:0] v;
        poke_mem(800, V5);
        poke_mem(801, V6);
        lw_reg(5'd5, 5'd0, 16'd3200);
        lw_reg(5'd6, 5'd0, 16'd3204);
        peek_reg(5'd5, v); chk("R5 rt/DR write, R3 store of B", v, V5);
        peek_reg(5'd6, v); chk("R5 rt/DR write, R3 store of B", v, V6);
    endtask

    task automatic t_alu();
        logic [31:0] v;
        rtype(5'd7, 5'd5, 5'd6, 3'd0); peek_reg(5'd7, v); chk("R7 add, R5 rd/Res, R6 B", v, V5 + V6);
        rtype(5'd7, 5'd5, 5'd6, 3'd1); peek_reg(5'd7, v); chk("R7 sub", v, V5 - V6);
        rtype(5'd7, 5'd5, 5'd6, 3'd2); peek_reg(5'd7, v); chk("R7 and", v, V5 & V6);
        rtype(5'd7, 5'd5, 5'd6, 3'd3); peek_reg(5'd7, v); chk("R7 or", v, V5 | V6);
        rtype(5'd7, 5'd5, 5'd6, 3'd4); peek_reg(5'd7, v); chk("R7 slt pos<neg", v, 32'd0);
        rtype(5'd7, 5'd6, 5'd5, 3'd4); peek_reg(5'd7, v); chk("R7 slt neg<pos", v, 32'd1);
        rtype(5'd7, 5'd5, 5'd6, 3'd5); peek_reg(5'd7, v); chk("R7 xor", v, V5 ^ V6);
    endtask

    task automatic t_zero_flag();
        load_ir({6'h00, 5'd5, 5'd5, 5'd0, 5'd0, 6'h22});
        a_we = 1'b1; b_we = 1'b1; cyc();
        asrc1_sel = 1'b1; asrc2_sel = 2'd0; alu_fn = 3'd1; #1;
        chk("R7 zero flag equal operands", {31'd0, alu_zero}, 32'd1);
        cyc();
        load_ir({6'h00, 5'd5, 5'd6, 5'd0, 5'd0, 6'h22});
        a_we = 1'b1; b_we = 1'b1; cyc();
        asrc1_sel = 1'b1; asrc2_sel = 2'd0; alu_fn = 3'd1; #1;
        chk("R7 zero flag unequal operands", {31'd0, alu_zero}, 32'd0);
        cyc();
    endtask

    task automatic t_reg_zero();
        logic [31:0] v;
        lw_reg(5'd0, 5'd0, 16'd3200);
        peek_reg(5'd0, v); chk("R4 register 0 ignores write", v, 32'd0);
    endtask

    task automatic t_neg_offset();
        logic [31:0] v;
        poke_mem(850, 32'hCAFE_0001);
        poke_mem(802, 32'd3404);
        lw_reg(5'd9, 5'd0, 16'd3208);
        lw_reg(5'd10, 5'd9, 16'hFFFC);
        peek_reg(5'd10, v); chk("R6 sign-extended negative offset, R4 rs into A", v, 32'hCAFE_0001);
    endtask

    task automatic t_ir_hold();
        logic [31:0] w1;
        w1 = 32'h0123_4567;
        load_ir(w1);
        poke_mem(int'(pc[11:2]), 32'h89AB_CDEF);
        cyc();
        chk("R2 IR holds without enable", ir_word, w1);
    endtask

    task automatic t_pc_inc();
        logic [31:0] p;
        p = pc;
        asrc1_sel = 1'b0; asrc2_sel = 2'd1; alu_fn = 3'd0; pc_src = 2'd1; pc_wr_u = 1'b1;
        cyc();
        chk("R8 ALU source PC+4, R6 const 4", pc, p + 32'd4);
        asrc1_sel = 1'b0; asrc2_sel = 2'd1; alu_fn = 3'd0; pc_src = 2'd1;
        cyc();
        chk("R9 PC holds with no write", pc, p + 32'd4);
    endtask

    task automatic t_jump();
        logic [31:0] p;
        load_ir({6'h02, 26'h000_0100});
        p = pc;
        pc_src = 2'd2; pc_wr_u = 1'b1;
        cyc();
        chk("R8 jump address", pc, {p[31:28], 26'h000_0100, 2'b00});
    endtask

    task automatic t_branch();
        logic [31:0] p;
        load_ir({6'h04, 5'd5, 5'd5, 16'hFFFE});
        p = pc;
        a_we = 1'b1; b_we = 1'b1;
        asrc1_sel = 1'b0; asrc2_sel = 2'd3; alu_fn = 3'd0; res_we = 1'b1;
        cyc();
        asrc1_sel = 1'b1; asrc2_sel = 2'd0; alu_fn = 3'd1; pc_src = 2'd0; pc_wr_c = 1'b1;
        cyc();
        chk("R9 conditional taken, R8 Res source, R6 branch offset", pc, p - 32'd8);
        load_ir({6'h04, 5'd5, 5'd6, 16'h0010});
        p = pc;
        a_we = 1'b1; b_we = 1'b1;
        asrc1_sel = 1'b0; asrc2_sel = 2'd3; alu_fn = 3'd0; res_we = 1'b1;
        cyc();
        asrc1_sel = 1'b1; asrc2_sel = 2'd0; alu_fn = 3'd1; pc_src = 2'd0; pc_wr_c = 1'b1;
        cyc();
        chk("R9 conditional not taken", pc, p);
    endtask

    initial begin
        clear_ctl();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        t_reset();
        t_load_store();
        t_alu();
        t_zero_flag();
        t_reg_zero();
        t_neg_offset();
        t_ir_hold();
        t_pc_inc();
        t_jump();
        t_branch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule